// File: doc/BRIEF.md
# I2S Transmit Controller

This block is a bus-programmed audio serial transmitter that acts as clock master. Software writes stereo samples into a left holding register and then a right holding register. The right-hand write pushes the pair into an eight-entry queue. A serial engine drains the queue one pair per frame. It generates the bit clock, the left/right select line and MSB-first serial data.

Four enable bits must all be set before the serial lines move: global, transmit block, clock generation and the channel's own transmit enable. The word length per half-frame comes from a clock configuration field. The sample resolution comes from a separate transmit configuration code. A queue-level trigger, an overrun flag and a mask register combine into a single interrupt output. Software normally sets the global enable first, then the block enable, then the clock enable. To stop, it clears the block enable first.

Top module: `i2s_tx_ctrl`

## Requirements
- R1: After reset, sclk, ws, sd and irq are low. The mask register (0x03C) reads 0x33 and the status register (0x038) reads 0x10.
- R2: sclk toggles only while bit 0 is set in all of these registers: global enable (0x000), block enable (0x008), clock enable (0x00C) and channel enable (0x02C). Otherwise sclk, ws and sd are held low.
- R3: Writing 0x020 loads the left holding register. Writing 0x024 pushes {left, written word} into an 8-pair queue. If 8 pairs are already queued, that write sets status bit 5 (overrun) and leaves the queue unchanged.
- R4: Any write to 0x044 clears status bit 5.
- R5: Status bit 4 is 1 exactly when the queue fill level is at or below the trigger level in bits 3:0 of 0x04C.
- R6: irq is high when status bit 4 or bit 5 is set and the matching bit of 0x03C is clear. A set mask bit suppresses its source.
- R7: Bits 4:3 of 0x010 set the half-frame length: 0 gives 16 sclk periods, 1 gives 24 and 2 gives 32.
- R8: ws is low for the left slot and high for the right slot. ws and sd change only on falling sclk. The slot MSB appears one sclk after ws changes.
- R9: Code 2, 4 or 5 in bits 2:0 of 0x034 selects a 16, 24 or 32-bit sample, taken right-justified from the written word. Slot bits beyond the sample are zero. A sample longer than the slot loses its low bits.
- R10: A frame that starts while the queue is empty transmits zeros in both slots.
- R11: The queue is emptied by clearing the global enable, or by writing 1 to bit 0 of 0x018 or of 0x054.
- R12: Each sclk phase lasts HALF_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial bit clock |
| ws | output | 1 | Left/right select |
| sd | output | 1 | Serial data |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets slot/resolution mismatches in both directions. A design that mis-indexed the right-justified sample would send upper garbage bits or drop the zero padding. It also targets the frame whose queue is already drained, where a design that repeated the last pair would fail the zero check. It fills the queue and then writes a ninth pair, then drains all nine frames. A design that overwrote an entry, or failed to raise the flag, would show a wrong ninth frame or a clear bit 5. It also sets three of the four enables, where a design that ignored any one of them would start toggling sclk.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

    localparam logic [8:0] OFS_GEN     = 9'h000;
    localparam logic [8:0] OFS_BLK     = 9'h008;
    localparam logic [8:0] OFS_CLKEN   = 9'h00C;
    localparam logic [8:0] OFS_CLKCFG  = 9'h010;
    localparam logic [8:0] OFS_TXRST   = 9'h018;
    localparam logic [8:0] OFS_LHOLD   = 9'h020;
    localparam logic [8:0] OFS_RHOLD   = 9'h024;
    localparam logic [8:0] OFS_CHEN    = 9'h02C;
    localparam logic [8:0] OFS_TXCFG   = 9'h034;
    localparam logic [8:0] OFS_STAT    = 9'h038;
    localparam logic [8:0] OFS_MASK    = 9'h03C;
    localparam logic [8:0] OFS_OVCLR   = 9'h044;
    localparam logic [8:0] OFS_TXLVL   = 9'h04C;
    localparam logic [8:0] OFS_TXFLUSH = 9'h054;

    typedef struct packed {
        logic [31:0] left;
        logic [31:0] right;
    } pair_t;

    typedef enum logic [1:0] {
        SLOT_16  = 2'd0,
        SLOT_24  = 2'd1,
        SLOT_32  = 2'd2,
        SLOT_RSV = 2'd3
    } slot_e;

    typedef struct packed {
        logic       run;
        slot_e      slot;
        logic [2:0] res;
    } txcfg_t;

    function automatic logic [5:0] slot_len(input slot_e s);
        case (s)
            SLOT_16: return 6'd16;
            SLOT_24: return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [5:0] res_len(input logic [2:0] c);
        case (c)
            3'd2:    return 6'd16;
            3'd4:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // Bit q of a frame (0 = left MSB position), for slot width w and sample width r.
    function automatic logic slot_bit(input pair_t p, input logic [5:0] q,
                                      input logic [5:0] w, input logic [5:0] r);
        logic [31:0] word;
        logic [5:0]  i;
        logic [4:0]  idx;
        if (q >= w) begin
            word = p.right;
            i    = q - w;
        end else begin
            word = p.left;
            i    = q;
        end
        idx = 5'(r - 6'd1 - i);
        return (i < r) ? word[idx] : 1'b0;
    endfunction

endpackage

// File: rtl/i2stx_fifo.sv
module i2stx_fifo
    import i2stx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  pair_t            push_data,
    input  logic             pop,
    output pair_t            head,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pair_t            mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [LVL_W-1:0] lvl_q;
    logic             do_push, do_pop;

    assign full    = (lvl_q == LVL_W'(DEPTH));
    assign empty   = (lvl_q == '0);
    assign level   = lvl_q;
    assign head    = mem[rp_q];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            case ({do_push, do_pop})
                2'b10:   lvl_q <= LVL_W'(lvl_q + 1'b1);
                2'b01:   lvl_q <= LVL_W'(lvl_q - 1'b1);
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // R3: a push into a full queue never displaces an entry
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> full);

    // R10: the serial engine only pops when a pair is present
    a_r10_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/i2stx_serial.sv
module i2stx_serial
    import i2stx_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  slot_e slot,
    input  logic [2:0] res,
    input  logic  fifo_empty,
    input  pair_t head,
    output logic  pop,
    output logic  sclk,
    output logic  ws,
    output logic  sd
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             sclk_q, ws_q, sd_q;
    logic [5:0]       pos_q;
    pair_t            cur_q;

    logic [5:0] w, r, last, np, q;
    logic       tick, fall, load;
    pair_t      src;

    assign w    = slot_len(slot);
    assign r    = res_len(res);
    assign last = 6'((w << 1) - 6'd1);
    assign tick = (div_q == DIV_W'(HALF_DIV - 1));
    assign fall = tick && sclk_q;
    assign np   = (pos_q >= last) ? 6'd0 : 6'(pos_q + 6'd1);
    assign q    = (np == 6'd0) ? last : 6'(np - 6'd1);
    assign load = fall && (np == 6'd1);
    assign src  = load ? (fifo_empty ? '0 : head) : cur_q;
    assign pop  = run && load && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
            ws_q   <= 1'b0;
            sd_q   <= 1'b0;
            pos_q  <= last;
            cur_q  <= '0;
        end else if (tick) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
                pos_q <= np;
                ws_q  <= (np >= w);
                cur_q <= src;
                sd_q  <= slot_bit(src, q, w, r);
            end
        end else begin
            div_q <= DIV_W'(div_q + 1'b1);
        end
    end

    assign sclk = sclk_q;
    assign ws   = ws_q;
    assign sd   = sd_q;

    // R2: serial lines fall idle once the enable chain drops
    a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!sclk_q && !ws_q && !sd_q));

    // R8: word select moves only with a falling bit clock
    a_r8_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(ws_q)) |-> $fell(sclk_q));

endmodule

// File: rtl/i2stx_regs.sv
module i2stx_regs
    import i2stx_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [8:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             fifo_full,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             push,
    output pair_t            push_pair,
    output logic             flush,
    output txcfg_t           cfg,
    output logic             irq
);
    logic             gen_q, blk_q, clken_q, chen_q, ovr_q;
    slot_e            slot_q;
    logic [2:0]       res_q;
    logic [5:0]       mask_q;
    logic [LVL_W-1:0] trig_q;
    logic [31:0]      lhold_q;
    logic             wr, empty_st;
    logic [5:0]       stat;

    assign wr = bus_sel && bus_wr;

    function automatic logic hit(input logic w_en, input logic [8:0] a, input logic [8:0] ofs);
        return w_en && (a == ofs);
    endfunction

    assign push      = hit(wr, bus_addr, OFS_RHOLD);
    assign push_pair = '{left: lhold_q, right: bus_wdata};
    assign flush     = !gen_q
                     || (hit(wr, bus_addr, OFS_TXRST)   && bus_wdata[0])
                     || (hit(wr, bus_addr, OFS_TXFLUSH) && bus_wdata[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q   <= 1'b0;
            blk_q   <= 1'b0;
            clken_q <= 1'b0;
            chen_q  <= 1'b0;
            slot_q  <= SLOT_16;
            res_q   <= 3'd2;
            mask_q  <= 6'h33;
            trig_q  <= '0;
            lhold_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (hit(wr, bus_addr, OFS_GEN))    gen_q   <= bus_wdata[0];
            if (hit(wr, bus_addr, OFS_BLK))    blk_q   <= bus_wdata[0];
            if (hit(wr, bus_addr, OFS_CLKEN))  clken_q <= bus_wdata[0];
            if (hit(wr, bus_addr, OFS_CHEN))   chen_q  <= bus_wdata[0];
            if (hit(wr, bus_addr, OFS_CLKCFG)) slot_q  <= slot_e'(bus_wdata[4:3]);
            if (hit(wr, bus_addr, OFS_TXCFG))  res_q   <= bus_wdata[2:0];
            if (hit(wr, bus_addr, OFS_MASK))   mask_q  <= bus_wdata[5:0];
            if (hit(wr, bus_addr, OFS_TXLVL))  trig_q  <= bus_wdata[LVL_W-1:0];
            if (hit(wr, bus_addr, OFS_LHOLD))  lhold_q <= bus_wdata;
            if (push && fifo_full)
                ovr_q <= 1'b1;
            else if (hit(wr, bus_addr, OFS_OVCLR))
                ovr_q <= 1'b0;
        end
    end

    assign empty_st = (fifo_level <= trig_q);
    assign stat     = {ovr_q, empty_st, 4'b0};
    assign irq      = |(stat[5:4] & ~mask_q[5:4]);

    assign cfg.run  = gen_q && blk_q && clken_q && chen_q;
    assign cfg.slot = slot_q;
    assign cfg.res  = res_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_GEN:    bus_rdata[0]       = gen_q;
            OFS_BLK:    bus_rdata[0]       = blk_q;
            OFS_CLKEN:  bus_rdata[0]       = clken_q;
            OFS_CHEN:   bus_rdata[0]       = chen_q;
            OFS_CLKCFG: bus_rdata[4:3]     = slot_q;
            OFS_TXCFG:  bus_rdata[2:0]     = res_q;
            OFS_STAT:   bus_rdata[5:0]     = stat;
            OFS_MASK:   bus_rdata[5:0]     = mask_q;
            OFS_TXLVL:  bus_rdata[LVL_W-1:0] = trig_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R3: writing a pair into a full queue raises overrun
    a_r3_ovr_set: assert property (@(posedge clk) disable iff (rst)
        (push && fifo_full) |=> ovr_q);

    // R4: the clear write drops overrun unless a new one arrives with it
    a_r4_ovr_clear: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_OVCLR && !(push && fifo_full)) |=> !ovr_q);

endmodule

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
    import i2stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int HALF_DIV   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [8:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        ws,
    output logic        sd,
    output logic        irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    pair_t            push_pair, head;
    txcfg_t           cfg;
    logic             push, pop, flush, full, empty;
    logic [LVL_W-1:0] level;

    i2stx_regs #(.LVL_W(LVL_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .fifo_full  (full),
        .fifo_level (level),
        .push       (push),
        .push_pair  (push_pair),
        .flush      (flush),
        .cfg        (cfg),
        .irq        (irq)
    );

    i2stx_fifo #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_data (push_pair),
        .pop       (pop),
        .head      (head),
        .full      (full),
        .empty     (empty),
        .level     (level)
    );

    i2stx_serial #(.HALF_DIV(HALF_DIV)) u_serial (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg.run),
        .slot       (cfg.slot),
        .res        (cfg.res),
        .fifo_empty (empty),
        .head       (head),
        .pop        (pop),
        .sclk       (sclk),
        .ws         (ws),
        .sd         (sd)
    );

endmodule

// File: tb/i2s_tx_ctrl_bench.sv
`timescale 1ns/1ps
module i2s_tx_ctrl_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        sclk, ws, sd, irq;

    i2s_tx_ctrl #(.FIFO_DEPTH(8), .HALF_DIV(HALF)) u_i2s_tx_ctrl (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .sclk(sclk), .ws(ws), .sd(sd), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0, ncap = 0;
    logic cap_on = 1'b0, sclk_prev = 1'b0;
    logic cap_sd [512];
    logic cap_ws [512];
    int   cap_t  [512];

    always @(negedge clk) begin
        cyc++;
        if (cap_on && sclk && !sclk_prev && ncap < 512) begin
            cap_sd[ncap] = sd;
            cap_ws[ncap] = ws;
            cap_t[ncap]  = cyc;
            ncap++;
        end
        sclk_prev = sclk;
    end

    typedef struct packed {
        logic [1:0]  slot;
        logic [2:0]  res;
        logic [31:0] l0, r0, l1, r1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 3'd2, 32'hFFFF_A5C3, 32'h0000_1234, 32'h0000_8001, 32'h0000_7FFE},
        '{2'd1, 3'd4, 32'h00AB_CDEF, 32'h0012_3456, 32'h0080_0000, 32'h0000_0001},
        '{2'd2, 3'd5, 32'hDEAD_BEEF, 32'h0123_4567, 32'h8000_0001, 32'hFFFF_FFFF},
        '{2'd2, 3'd2, 32'h0000_C0DE, 32'h0000_1F2E, 32'hFFFF_8000, 32'h0000_0001},
        '{2'd0, 3'd4, 32'h00AB_CDEF, 32'h0065_4321, 32'h0000_00FF, 32'h00FF_0000}
    };

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    function automatic logic [31:0] expect_slot(input logic [31:0] s, input int w, input int r);
        logic [31:0] v = '0;
        for (int i = 0; i < w; i++)
            v = {v[30:0], (i < r) ? s[r-1-i] : 1'b0};
        return v;
    endfunction

    function automatic logic [31:0] grab(input int start, input int w);
        logic [31:0] v = '0;
        for (int i = 0; i < w; i++)
            v = {v[30:0], cap_sd[start+i]};
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "sclk/ws/sd/irq", {28'b0, sclk, ws, sd, irq}, 32'h0);
        bus_read(9'h03C, rd); check("R1", "mask", rd, 32'h33);
        bus_read(9'h038, rd); check("R1", "status", rd, 32'h10);

        // Vector table: R7, R8, R9, R10, R12
        for (int k = 0; k < 5; k++) begin
            vec_t v;
            int w, r, fr, wsbad;
            v = VECS[k];
            w = (v.slot == 2'd0) ? 16 : (v.slot == 2'd1) ? 24 : 32;
            r = (v.res == 3'd2) ? 16 : (v.res == 3'd4) ? 24 : 32;
            bus_write(9'h000, 0);
            bus_write(9'h008, 0);
            bus_write(9'h010, {27'b0, v.slot, 3'b0});
            bus_write(9'h034, {29'b0, v.res});
            bus_write(9'h02C, 1);
            bus_write(9'h00C, 1);
            bus_write(9'h000, 1);
            bus_write(9'h020, v.l0); bus_write(9'h024, v.r0);
            bus_write(9'h020, v.l1); bus_write(9'h024, v.r1);
            ncap = 0; cap_on = 1'b1;
            bus_write(9'h008, 1);
            while (ncap < 6*w + 2) @(negedge clk);
            cap_on = 1'b0;
            bus_write(9'h008, 0);
            fr = 2*w;
            check("R9", "frame0 left",  grab(2, w),          expect_slot(v.l0, w, r));
            check("R9", "frame0 right", grab(2 + w, w),      expect_slot(v.r0, w, r));
            check("R7", "frame1 left",  grab(2 + fr, w),     expect_slot(v.l1, w, r));
            check("R7", "frame1 right", grab(2 + fr + w, w), expect_slot(v.r1, w, r));
            check("R10", "frame2 left",  grab(2 + 2*fr, w),     32'h0);
            check("R10", "frame2 right", grab(2 + 2*fr + w, w), 32'h0);
            wsbad = 0;
            for (int i = 1; i < 6*w + 2; i++)
                if (cap_ws[i] !== (((i - 1) % fr) >= w)) wsbad++;
            check("R8", "ws pattern errors", wsbad, 0);
            check("R12", "sclk period", cap_t[3] - cap_t[2], 2*HALF);
        end

        // R2 enable gating: channel enable low
        bus_write(9'h02C, 0);
        bus_write(9'h008, 1);
        ncap = 0; cap_on = 1'b1;
        repeat (40) @(negedge clk);
        check("R2", "sclk rises with channel off", ncap, 0);
        bus_write(9'h02C, 1);
        repeat (20) @(negedge clk);
        check("R2", "sclk running", (ncap > 0), 1);
        cap_on = 1'b0;
        bus_write(9'h008, 0);
        @(negedge clk);
        check("R2", "idle after block off", {29'b0, sclk, ws, sd}, 0);

        // R5 trigger level
        bus_write(9'h000, 0); bus_write(9'h000, 1);
        bus_write(9'h04C, 2);
        for (int i = 0; i < 2; i++) begin bus_write(9'h020, i); bus_write(9'h024, i); end
        bus_read(9'h038, rd); check("R5", "level 2 trig 2", rd, 32'h10);
        bus_write(9'h020, 7); bus_write(9'h024, 7);
        bus_read(9'h038, rd); check("R5", "level 3 trig 2", rd, 32'h00);

        // R6 masking, R11 flush register
        bus_write(9'h03C, 32'h20);
        check("R6", "irq with no source", irq, 0);
        bus_write(9'h054, 1);
        bus_read(9'h038, rd); check("R11", "flush 0x054", rd, 32'h10);
        check("R6", "irq empty unmasked", irq, 1);
        bus_write(9'h03C, 32'h33);
        check("R6", "irq all masked", irq, 0);

        // R3 overrun, R4 clear
        for (int i = 0; i < 8; i++) begin
            bus_write(9'h020, 32'h100 + i); bus_write(9'h024, 32'h200 + i);
        end
        bus_read(9'h038, rd); check("R3", "eight queued", rd, 32'h00);
        bus_write(9'h020, 32'hAAAA); bus_write(9'h024, 32'h5555);
        bus_read(9'h038, rd); check("R3", "overrun flag", rd, 32'h20);
        bus_write(9'h03C, 32'h13);
        check("R6", "irq overrun unmasked", irq, 1);
        bus_write(9'h044, 0);
        bus_read(9'h038, rd); check("R4", "overrun cleared", rd, 32'h00);
        check("R4", "irq after clear", irq, 0);
        bus_write(9'h03C, 32'h33);

        // R3 dropped ninth pair: drain nine frames at 16/16
        bus_write(9'h010, 0); bus_write(9'h034, 2);
        ncap = 0; cap_on = 1'b1;
        bus_write(9'h008, 1);
        while (ncap < 2 + 9*32) @(negedge clk);
        cap_on = 1'b0;
        bus_write(9'h008, 0);
        check("R3", "first pair left", grab(2, 16), 32'h0100);
        check("R3", "eighth pair right", grab(2 + 7*32 + 16, 16), 32'h0207);
        check("R3", "ninth frame left", grab(2 + 8*32, 16), 32'h0);
        check("R3", "ninth frame right", grab(2 + 8*32 + 16, 16), 32'h0);

        // R11 global-disable flush and reset register
        for (int i = 0; i < 3; i++) begin bus_write(9'h020, i); bus_write(9'h024, i); end
        bus_read(9'h038, rd); check("R11", "three queued", rd, 32'h00);
        bus_write(9'h000, 0);
        bus_read(9'h038, rd); check("R11", "global clear flush", rd, 32'h10);
        bus_write(9'h000, 1);
        for (int i = 0; i < 3; i++) begin bus_write(9'h020, i); bus_write(9'h024, i); end
        bus_write(9'h018, 1);
        bus_read(9'h038, rd); check("R11", "flush 0x018", rd, 32'h10);

        finish_run();
    end
endmodule